// File: doc/BRIEF.md
# SMBus Slave Packet Error Checker

This block sits next to the shift register of a two-wire serial slave. Each bit that moves on the bus, in either direction, arrives as a one-cycle strobe with its value. The block keeps a running CRC-8 over those bits. It also keeps a count of remaining data bytes, loaded from a programmed length at the start of each transfer phase. When packet error checking is enabled and the count has run out, the next byte is the check byte.

In receive mode the block checks that byte against its own CRC and issues the ACK or NAK for it. A mismatch also sets a sticky error flag. In transmit mode it presents the CRC byte for the shifter to send.

A combinational matcher compares an incoming 7-bit address with the programmed own address. It can also match the two reserved protocol addresses, each under its own enable. The CRC is cleared only by reset or an explicit clear strobe, so a chain of linked transfers shares one check value.

Top module: `smb_pec_unit`

## Requirements
- R1: After reset `crc_out` is 0x00, `cnt_left` is 0, `pec_err` is 0 and `resp_valid` is 0.
- R2: On every cycle with `bit_stb` high and `crc_clr` low, the CRC advances one step, whatever the value of `rx_mode`. The CRC uses polynomial 0x07 (x^8+x^2+x+1), starts from 0x00 and takes bits MSB first. `crc_out` shows the new value in the following cycle.
- R3: `crc_clr` sets the CRC to 0x00 and restarts the bit position within the byte. `len_load` leaves the CRC untouched, so linked transfers accumulate one CRC.
- R4: `len_load` copies `len_value` into `cnt_left`. Each completed byte (every eighth strobe) decrements `cnt_left` while it is nonzero. At zero the count holds.
- R5: In receive mode (`rx_mode`=1), `resp_valid` pulses for one cycle in the cycle after each completed byte. For a data byte, `resp_nak` is 0 (ACK).
- R6: A received byte that completes while `pec_en`=1 and `cnt_left`=0 is the check byte. It is ACKed (`resp_nak`=0) when the CRC over all bits, including that byte, is 0x00. Otherwise it is NAKed (`resp_nak`=1).
- R7: `pec_err` is set together with every NAKed check byte. It stays set until reset.
- R8: In transmit mode, `tx_pec_sel` is 1 exactly when `pec_en`=1 and `cnt_left`=0. At a byte boundary, `tx_pec_byte` equals the CRC over all bits sent since the last clear.
- R9: With `pec_en`=0, no check byte exists. Received bytes at count zero are ACKed, `pec_err` is unchanged, and `tx_pec_sel` stays 0.
- R10: `addr_hit` is 1 when `addr_in` equals `own_addr`. It is also 1 when `addr_in` is 0x0C with `ara_en`=1, or 0x08 with `hh_en`=1. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pec_en | input | 1 | Packet error checking enabled for this transfer |
| rx_mode | input | 1 | 1 = slave receive, 0 = slave transmit |
| len_load | input | 1 | Load the byte count at the start of a transfer phase |
| len_value | input | LEN_W | Number of data bytes in the phase |
| bit_stb | input | 1 | One bit moved on the bus this cycle |
| bit_val | input | 1 | Value of that bit |
| crc_clr | input | 1 | Clear the CRC (end of packet) |
| own_addr | input | 7 | Programmed slave address |
| ara_en | input | 1 | Also match the alert response address 0x0C |
| hh_en | input | 1 | Also match the host header address 0x08 |
| addr_in | input | 7 | Received address |
| addr_hit | output | 1 | Address matched |
| crc_out | output | 8 | Running CRC |
| cnt_left | output | LEN_W | Remaining data bytes |
| tx_pec_sel | output | 1 | Transmitter must send the check byte now |
| tx_pec_byte | output | 8 | Check byte to transmit |
| resp_valid | output | 1 | ACK/NAK decision for the last received byte |
| resp_nak | output | 1 | 1 = NAK |
| pec_err | output | 1 | Sticky check-byte mismatch |

## Verification
A wrong CRC step shows on `crc_out` one cycle after the faulty strobe. It then corrupts every later check byte. A sweep of all 256 single-byte values from a cleared state exposes any polynomial or bit-order fault immediately.

A bit-position or count error moves the check byte to the wrong place. That shows as an early or late `tx_pec_sel`, or as an ACK/NAK decision on the wrong byte, within one byte time.

A flipped check byte must show NAK and `pec_err` in the cycle after its eighth bit.

// File: rtl/smb_pec_unit.sv
module smb_pec_unit #(
  parameter int          LEN_W    = 8,
  parameter logic [6:0]  ARA_ADDR = 7'h0C,
  parameter logic [6:0]  HH_ADDR  = 7'h08
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pec_en,
  input  logic             rx_mode,
  input  logic             len_load,
  input  logic [LEN_W-1:0] len_value,
  input  logic             bit_stb,
  input  logic             bit_val,
  input  logic             crc_clr,
  input  logic [6:0]       own_addr,
  input  logic             ara_en,
  input  logic             hh_en,
  input  logic [6:0]       addr_in,
  output logic             addr_hit,
  output logic [7:0]       crc_out,
  output logic [LEN_W-1:0] cnt_left,
  output logic             tx_pec_sel,
  output logic [7:0]       tx_pec_byte,
  output logic             resp_valid,
  output logic             resp_nak,
  output logic             pec_err
);

  logic [7:0]       crc, crc_nx, snap;
  logic [2:0]       bitpos;
  logic [LEN_W-1:0] cnt;
  logic             byte_done, pec_phase, bad_pec;

  assign crc_nx    = {crc[6:0], 1'b0} ^ ((crc[7] ^ bit_val) ? 8'h07 : 8'h00);
  assign byte_done = bit_stb && !crc_clr && (bitpos == 3'd7);
  assign pec_phase = pec_en && (cnt == '0);
  assign bad_pec   = byte_done && rx_mode && pec_phase && (crc_nx != 8'h00);

  assign addr_hit    = (addr_in == own_addr) ||
                       (ara_en && addr_in == ARA_ADDR) ||
                       (hh_en  && addr_in == HH_ADDR);
  assign crc_out     = crc;
  assign cnt_left    = cnt;
  assign tx_pec_sel  = pec_phase && !rx_mode;
  assign tx_pec_byte = snap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc        <= 8'h00;
      snap       <= 8'h00;
      bitpos     <= 3'd0;
      cnt        <= '0;
      resp_valid <= 1'b0;
      resp_nak   <= 1'b0;
      pec_err    <= 1'b0;
    end else begin
      if (crc_clr) begin
        crc    <= 8'h00;
        snap   <= 8'h00;
        bitpos <= 3'd0;
      end else if (bit_stb) begin
        crc    <= crc_nx;
        bitpos <= bitpos + 3'd1;
        if (byte_done) snap <= crc_nx;
      end
      if (len_load) begin
        cnt    <= len_value;
        bitpos <= 3'd0;
      end else if (byte_done && cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
      resp_valid <= byte_done && rx_mode;
      resp_nak   <= bad_pec;
      pec_err    <= pec_err | bad_pec;
    end
  end

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pec_err |=> pec_err);

  // R7
  err_with_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pec_err) |-> (resp_valid && resp_nak));

  // R5
  nak_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_nak |-> resp_valid);

  // R3
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crc_clr |=> (crc_out == 8'h00));

  // R4
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !len_load && cnt_left != '0) |=> (cnt_left == $past(cnt_left) - 1'b1));

  // R9
  no_pec_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pec_en |-> !tx_pec_sel);

endmodule

// File: tb/smb_pec_unit_tb.sv
module smb_pec_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pec_en = 1'b0, rx_mode = 1'b0, len_load = 1'b0;
  logic [7:0] len_value = 8'd0;
  logic       bit_stb = 1'b0, bit_val = 1'b0, crc_clr = 1'b0;
  logic [6:0] own_addr = 7'h2A, addr_in = 7'h00;
  logic       ara_en = 1'b0, hh_en = 1'b0;
  logic       addr_hit, tx_pec_sel, resp_valid, resp_nak, pec_err;
  logic [7:0] crc_out, tx_pec_byte, cnt_left;

  int n_chk = 0, n_bad = 0;
  logic last_rv, last_nak;
  logic [7:0] model;

  always #5 clk = ~clk;

  smb_pec_unit #(.LEN_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .pec_en(pec_en), .rx_mode(rx_mode),
    .len_load(len_load), .len_value(len_value), .bit_stb(bit_stb),
    .bit_val(bit_val), .crc_clr(crc_clr), .own_addr(own_addr),
    .ara_en(ara_en), .hh_en(hh_en), .addr_in(addr_in), .addr_hit(addr_hit),
    .crc_out(crc_out), .cnt_left(cnt_left), .tx_pec_sel(tx_pec_sel),
    .tx_pec_byte(tx_pec_byte), .resp_valid(resp_valid), .resp_nak(resp_nak),
    .pec_err(pec_err));

  function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] r = c;
    for (int i = 7; i >= 0; i--) begin
      logic top = r[7] ^ b[i];
      r = r << 1;
      if (top) r = r ^ 8'h07;
    end
    return r;
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk); bit_stb = 1'b1; bit_val = b[i];
    end
    @(negedge clk); bit_stb = 1'b0;
    last_rv = resp_valid; last_nak = resp_nak;
    model = ref_crc(model, b);
  endtask

  task automatic clear_crc();
    @(negedge clk); crc_clr = 1'b1;
    @(negedge clk); crc_clr = 1'b0;
    model = 8'h00;
  endtask

  task automatic load_len(input logic [7:0] n);
    @(negedge clk); len_load = 1'b1; len_value = n;
    @(negedge clk); len_load = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; repeat (2) @(negedge clk); rst_n = 1'b1; model = 8'h00;
  endtask

  initial begin
    #1500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] pec;
    do_reset();
    @(negedge clk);
    chk(crc_out == 0 && cnt_left == 0 && !pec_err && !resp_valid, "R1 reset state",
        {crc_out, cnt_left}, 0);

    // R2 all single bytes from a clear state, transmit mode
    for (int v = 0; v < 256; v++) begin
      clear_crc();
      send_byte(v[7:0]);
      chk(crc_out == model, "R2 single byte crc", crc_out, model);
    end
    // R2 long random stream in receive mode
    clear_crc(); rx_mode = 1'b1;
    for (int k = 0; k < 64; k++) begin
      send_byte(8'($urandom));
      chk(crc_out == model, "R2 stream crc", crc_out, model);
    end

    // R3 len_load keeps crc, clear zeroes it
    pec = crc_out;
    load_len(8'd4);
    chk(crc_out == pec, "R3 load keeps crc", crc_out, pec);
    chk(cnt_left == 4, "R4 count loaded", cnt_left, 4);
    clear_crc(); @(negedge clk);
    chk(crc_out == 0, "R3 clear crc", crc_out, 0);

    // R4 R5 R6 receive with check byte
    pec_en = 1'b1; rx_mode = 1'b1;
    clear_crc(); load_len(8'd3);
    for (int k = 0; k < 3; k++) begin
      send_byte(8'($urandom));
      chk(cnt_left == 8'(2 - k), "R4 count step", cnt_left, 2 - k);
      chk(last_rv && !last_nak, "R5 data ack", {last_rv, last_nak}, 2);
    end
    send_byte(model);
    chk(last_rv && !last_nak, "R6 good pec ack", {last_rv, last_nak}, 2);
    chk(!pec_err, "R7 no error on good pec", pec_err, 0);
    chk(cnt_left == 0, "R4 count holds", cnt_left, 0);

    // R6 R7 every single-bit flip of the check byte
    for (int f = 0; f < 8; f++) begin
      clear_crc(); load_len(8'd2);
      send_byte(8'h5A + 8'(f)); send_byte(8'h3C);
      pec = model ^ (8'h01 << f);
      send_byte(pec);
      chk(last_rv && last_nak, "R6 flipped pec nak", {last_rv, last_nak}, 3);
      chk(pec_err, "R7 error set", pec_err, 1);
    end
    clear_crc(); load_len(8'd1);
    send_byte(8'h11); send_byte(model);
    chk(!last_nak && pec_err, "R7 error sticky", {last_nak, pec_err}, 1);

    // R8 transmit: check byte offered after data
    do_reset(); rx_mode = 1'b0; pec_en = 1'b1;
    load_len(8'd2);
    chk(!tx_pec_sel, "R8 no sel during data", tx_pec_sel, 0);
    send_byte(8'hA7);
    chk(!tx_pec_sel, "R8 no sel after first byte", tx_pec_sel, 0);
    send_byte(8'h42);
    chk(tx_pec_sel, "R8 sel at zero", tx_pec_sel, 1);
    chk(tx_pec_byte == model, "R8 pec byte value", tx_pec_byte, model);
    chk(!last_rv, "R5 no response in transmit", last_rv, 0);

    // R9 disabled: no check byte
    do_reset(); pec_en = 1'b0; rx_mode = 1'b1;
    load_len(8'd0);
    send_byte(8'hFF);
    chk(last_rv && !last_nak, "R9 ack at zero when disabled", {last_rv, last_nak}, 2);
    chk(!pec_err, "R9 no error when disabled", pec_err, 0);
    rx_mode = 1'b0; @(negedge clk);
    chk(!tx_pec_sel, "R9 no tx pec when disabled", tx_pec_sel, 0);

    // R10 address sweep
    for (int e = 0; e < 4; e++) begin
      for (int a = 0; a < 128; a++) begin
        logic exp;
        ara_en = e[0]; hh_en = e[1]; addr_in = a[6:0];
        #1;
        exp = (a == 'h2A) || (e[0] && a == 'h0C) || (e[1] && a == 'h08);
        chk(addr_hit == exp, "R10 address match", addr_hit, exp);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule